// File: doc/BRIEF.md
# Power Button Controller

This block conditions a raw power-button pin and turns it into button status, a button interrupt, and the on-request line that keeps an external power-management IC supplying the system. A two-flop synchronizer feeds a debounce filter. The debounce filter counts a 1 kHz millisecond tick-enable, so every time value is a number of ticks. A 3-bit mode selects one of five behaviours: the button is active at a low level or a high level, or it reacts to a rising edge, a falling edge or either edge. The mode sets which debounced transitions raise the interrupt flag and which level counts as "pressed".

A press held for a selectable long-press time forces an emergency power-off. Software can also switch the system off with a one-cycle command. While the system is off, a fresh press held for the selected on-time switches it back on. The on-request output can be forced active. It can also be disabled, so that only the forcing bit drives it.

Every pin is a plain level or a one-cycle pulse, sampled on the rising clock edge. No data stream passes through the block, so no pin takes part in a valid/ready handshake and there is no back-pressure. The configuration inputs are expected to come straight from a control register. The three clear inputs are write-one-to-clear strobes.

Top module: `pbc_power_button`

## Requirements
- R1: The raw pin passes through two synchronizer flops. The debounced level takes the synchronized value only after that value has differed from it on 50, 100 or 500 tick cycles in a row, for debounce code 0, 1 or 2. Any cycle on which the two agree restarts the count, and the count advances only on cycles where `ms_tick` is high.
- R2: With debounce code 3 the debounced level follows the synchronized pin one cycle later, so a pin change shows up three clock edges after it is driven.
- R3: `sts_btn_level` shows whether the debounced button is pressed. Modes 0 (active low) and 3 (falling edge) treat a low level as pressed. Modes 1 (active high), 2 (rising edge) and 4 (either edge) treat a high level as pressed. Modes 5 to 7 never report a press.
- R4: In modes 0 and 1 the interrupt flag sets on every cycle that the button is pressed. In modes 2, 3 and 4 it sets only on a debounced rise, a debounced fall or either of the two, respectively.
- R5: `clr_btn_irq` clears the interrupt flag one edge later. If a set condition occurs in the same cycle, the set wins.
- R6: `cfg_irq_mask` gates only the `btn_irq` output. The `sts_btn_irq` flag still sets and holds while the mask is on.
- R7: A press held for 5000, 10000 or 15000 ticks (long-press code 0, 1 or 2) sets `sts_emerg_off` and powers the system off. This happens once per press. Long-press code 3 disables the feature.
- R8: While the system is off, the button must first be seen released. A press held after that for 500, 50 or 100 ticks (on-time code 0, 1 or 2) powers the system on. With on-time code 3 the system powers on at the first pressed cycle.
- R9: A one-cycle `cmd_power_off` powers the system off and sets `sts_sw_off`.
- R10: `pmic_on_req` equals `cfg_req_force`, or `cfg_req_enable` while the system is powered. After reset the system is powered.
- R11: Reset clears the synchronizer, the debounced level (to 0), the counters and all three flags.
- R12: `clr_emerg` and `clr_sw_off` clear their flags. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond tick-enable |
| btn_raw | input | 1 | Unsynchronized button pin |
| cfg_mode | input | 3 | Button mode: 0 active low, 1 active high, 2 rising, 3 falling, 4 either edge |
| cfg_debounce | input | 2 | Debounce code: 0=50, 1=100, 2=500 ticks, 3=none |
| cfg_long_press | input | 2 | Long-press code: 0=5000, 1=10000, 2=15000 ticks, 3=disabled |
| cfg_on_time | input | 2 | On-time code: 0=500, 1=50, 2=100 ticks, 3=none |
| cfg_irq_mask | input | 1 | Masks the `btn_irq` output |
| cfg_req_enable | input | 1 | Lets the power state drive `pmic_on_req` |
| cfg_req_force | input | 1 | Forces `pmic_on_req` active |
| cmd_power_off | input | 1 | One-cycle software power-off command |
| clr_btn_irq | input | 1 | Clears the button interrupt flag |
| clr_emerg | input | 1 | Clears the emergency-off flag |
| clr_sw_off | input | 1 | Clears the software-off flag |
| sts_btn_level | output | 1 | Debounced pressed state |
| sts_btn_irq | output | 1 | Button interrupt flag |
| btn_irq | output | 1 | Masked interrupt request |
| sts_emerg_off | output | 1 | Long-press emergency-off flag |
| sts_sw_off | output | 1 | Software power-off flag |
| pmic_on_req | output | 1 | Power-on request to the PMIC |

## Verification
The bench drives glitches shorter than the debounce window while ticks arrive only every third cycle. A filter that counted clocks instead of ticks, or that did not restart its count when the pin returned, would let those glitches through. It holds presses to just below and just above each long-press and on-time limit. An off-by-one counter would then fire one tick early or late, and a missing re-arm on release would switch the power straight back on after an emergency-off. It sweeps every mode and checks clears that collide with a set, where a design that put the clear first would lose an event or drop a level-mode flag while the button is still held.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [2:0] {
    MODE_ACT_LOW  = 3'd0,
    MODE_ACT_HIGH = 3'd1,
    MODE_RISE     = 3'd2,
    MODE_FALL     = 3'd3,
    MODE_ANY_EDGE = 3'd4
  } btn_mode_e;

  // Code 3 of every 2-bit timing selector means "none" or "disabled".
  localparam logic [1:0] SEL_OFF = 2'd3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pbc_debounce.sv
module pbc_debounce
  import pbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T0 = 50,
  parameter int T1 = 100,
  parameter int T2 = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       raw,
  input  logic [1:0] sel,
  output logic       level
);
  localparam int TMAX = max3(T0, T1, T2);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int CW1  = CW + 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   sampled;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          lim;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= raw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
    end
  end

  assign sampled = chain[SYNC_STAGES-1];

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(T0);
      2'd1:    lim = CW'(T1);
      2'd2:    lim = CW'(T2);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (sampled == level) begin
      cnt <= '0;
    end else if (sel == SEL_OFF) begin
      level <= sampled;
      cnt   <= '0;
    end else if (tick) begin
      if (CW1'(cnt) + 1'b1 >= CW1'(lim)) begin
        level <= sampled;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: with filtering on, the debounced level moves only on a tick cycle
  a_r1_change_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
    ((level != $past(level)) && ($past(sel) != SEL_OFF)) |-> $past(tick));

  // R1: the filtered level only ever takes the synchronized value
  a_r1_takes_sampled : assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> (level == $past(sampled)));

endmodule

// File: rtl/pbc_event.sv
module pbc_event
  import pbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       level,
  input  logic       clr,
  output logic       pressed,
  output logic       irq_flag
);
  logic prev;
  logic rise, fall, ev;

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  always_comb begin
    case (mode)
      MODE_ACT_LOW:  pressed = ~level;
      MODE_ACT_HIGH: pressed = level;
      MODE_RISE:     pressed = level;
      MODE_FALL:     pressed = ~level;
      MODE_ANY_EDGE: pressed = level;
      default:       pressed = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_ACT_LOW:  ev = ~level;
      MODE_ACT_HIGH: ev = level;
      MODE_RISE:     ev = rise;
      MODE_FALL:     ev = fall;
      MODE_ANY_EDGE: ev = rise | fall;
      default:       ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      prev <= level;
      if (ev)       irq_flag <= 1'b1;
      else if (clr) irq_flag <= 1'b0;
    end
  end

  // R5: the flag drops only after a clear request
  a_r5_clear_only_on_request : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(clr));

  // R4: in edge modes the flag rises only after a debounced transition
  a_r4_edge_needs_change : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_flag) && ($past(mode) inside {3'd2, 3'd3, 3'd4}))
      |-> ($past(level) != $past(prev)));

endmodule

// File: rtl/pbc_power.sv
module pbc_power
  import pbc_pkg::*;
#(
  parameter int LP0 = 5000,
  parameter int LP1 = 10000,
  parameter int LP2 = 15000,
  parameter int ON0 = 500,
  parameter int ON1 = 50,
  parameter int ON2 = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pressed,
  input  logic [1:0] lp_sel,
  input  logic [1:0] on_sel,
  input  logic       cmd_off,
  input  logic       clr_eo,
  input  logic       clr_spo,
  output logic       pwr_on,
  output logic       eo,
  output logic       spo
);
  localparam int LW = $clog2(max3(LP0, LP1, LP2) + 1);
  localparam int OW = $clog2(max3(ON0, ON1, ON2) + 1);

  logic [LW-1:0] lp_cnt, lp_lim;
  logic [OW-1:0] on_cnt, on_lim;
  logic          armed;
  logic          lp_hit, on_hit, go_off;

  always_comb begin
    case (lp_sel)
      2'd0:    lp_lim = LW'(LP0);
      2'd1:    lp_lim = LW'(LP1);
      2'd2:    lp_lim = LW'(LP2);
      default: lp_lim = '0;
    endcase
    case (on_sel)
      2'd0:    on_lim = OW'(ON0);
      2'd1:    on_lim = OW'(ON1);
      2'd2:    on_lim = OW'(ON2);
      default: on_lim = '0;
    endcase
  end

  // Long-press timer: saturates at its limit so it fires once per press.
  assign lp_hit = pressed && tick && (lp_sel != SEL_OFF) &&
                  (lp_cnt == lp_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        lp_cnt <= '0;
    else if (!pressed)                 lp_cnt <= '0;
    else if (tick && lp_cnt < lp_lim)  lp_cnt <= lp_cnt + 1'b1;
  end

  // On-time timer: runs only while off, after a release has been seen.
  assign on_hit = !pwr_on && armed && pressed &&
                  ((on_sel == SEL_OFF) || (tick && on_cnt == on_lim - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      on_cnt <= '0;
    end else begin
      if (pwr_on)        armed <= 1'b0;
      else if (!pressed) armed <= 1'b1;

      if (pwr_on || !armed || !pressed)  on_cnt <= '0;
      else if (tick && on_cnt < on_lim)  on_cnt <= on_cnt + 1'b1;
    end
  end

  assign go_off = lp_hit | cmd_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_on <= 1'b1;
      eo     <= 1'b0;
      spo    <= 1'b0;
    end else begin
      if (go_off)      pwr_on <= 1'b0;
      else if (on_hit) pwr_on <= 1'b1;

      if (lp_hit)      eo <= 1'b1;
      else if (clr_eo) eo <= 1'b0;

      if (cmd_off)      spo <= 1'b1;
      else if (clr_spo) spo <= 1'b0;
    end
  end

  // R7: emergency-off needs a held press with the feature enabled
  a_r7_eo_needs_hold : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eo) |-> ($past(pressed) && ($past(lp_sel) != SEL_OFF)));

  // R9: the software-off flag rises only on the command
  a_r9_spo_on_cmd : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spo) |-> $past(cmd_off));

  // R8: power returns only on an armed press
  a_r8_on_needs_armed_press : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> ($past(pressed) && $past(armed)));

  // R7 / R9: power drops only on a command or during a press
  a_r7_off_has_cause : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on) |-> ($past(cmd_off) || $past(pressed)));

endmodule

// File: rtl/pbc_power_button.sv
module pbc_power_button
  import pbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DB_T0 = 50,
  parameter int DB_T1 = 100,
  parameter int DB_T2 = 500,
  parameter int LP_T0 = 5000,
  parameter int LP_T1 = 10000,
  parameter int LP_T2 = 15000,
  parameter int ON_T0 = 500,
  parameter int ON_T1 = 50,
  parameter int ON_T2 = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       btn_raw,
  input  logic [2:0] cfg_mode,
  input  logic [1:0] cfg_debounce,
  input  logic [1:0] cfg_long_press,
  input  logic [1:0] cfg_on_time,
  input  logic       cfg_irq_mask,
  input  logic       cfg_req_enable,
  input  logic       cfg_req_force,
  input  logic       cmd_power_off,
  input  logic       clr_btn_irq,
  input  logic       clr_emerg,
  input  logic       clr_sw_off,
  output logic       sts_btn_level,
  output logic       sts_btn_irq,
  output logic       btn_irq,
  output logic       sts_emerg_off,
  output logic       sts_sw_off,
  output logic       pmic_on_req
);
  logic db_level;
  logic pressed;
  logic pwr_on;

  pbc_debounce #(
    .SYNC_STAGES(SYNC_STAGES), .T0(DB_T0), .T1(DB_T1), .T2(DB_T2)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .raw(btn_raw),
    .sel(cfg_debounce), .level(db_level)
  );

  pbc_event u_event (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .level(db_level),
    .clr(clr_btn_irq), .pressed(pressed), .irq_flag(sts_btn_irq)
  );

  pbc_power #(
    .LP0(LP_T0), .LP1(LP_T1), .LP2(LP_T2),
    .ON0(ON_T0), .ON1(ON_T1), .ON2(ON_T2)
  ) u_power (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .pressed(pressed),
    .lp_sel(cfg_long_press), .on_sel(cfg_on_time), .cmd_off(cmd_power_off),
    .clr_eo(clr_emerg), .clr_spo(clr_sw_off),
    .pwr_on(pwr_on), .eo(sts_emerg_off), .spo(sts_sw_off)
  );

  assign sts_btn_level = pressed;
  assign btn_irq       = sts_btn_irq & ~cfg_irq_mask;
  assign pmic_on_req   = cfg_req_force | (cfg_req_enable & pwr_on);

  // R10: without the force bit, a request needs the enable bit
  a_r10_request_gated : assert property (@(posedge clk) disable iff (!rst_n)
    (pmic_on_req && !cfg_req_force) |-> cfg_req_enable);

endmodule

// File: tb/pbc_power_button_test.sv
module pbc_power_button_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       btn_raw = 1'b0;
  logic [2:0] cfg_mode = 3'd1;
  logic [1:0] cfg_debounce = 2'd0;
  logic [1:0] cfg_long_press = 2'd3;
  logic [1:0] cfg_on_time = 2'd0;
  logic       cfg_irq_mask = 1'b0;
  logic       cfg_req_enable = 1'b1;
  logic       cfg_req_force = 1'b0;
  logic       cmd_power_off = 1'b0;
  logic       clr_btn_irq = 1'b0;
  logic       clr_emerg = 1'b0;
  logic       clr_sw_off = 1'b0;
  logic       sts_btn_level, sts_btn_irq, btn_irq;
  logic       sts_emerg_off, sts_sw_off, pmic_on_req;

  int errors = 0;
  int checks = 0;
  int tick_div = 1;
  int phase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pbc_power_button uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_raw(btn_raw),
    .cfg_mode(cfg_mode), .cfg_debounce(cfg_debounce),
    .cfg_long_press(cfg_long_press), .cfg_on_time(cfg_on_time),
    .cfg_irq_mask(cfg_irq_mask), .cfg_req_enable(cfg_req_enable),
    .cfg_req_force(cfg_req_force), .cmd_power_off(cmd_power_off),
    .clr_btn_irq(clr_btn_irq), .clr_emerg(clr_emerg), .clr_sw_off(clr_sw_off),
    .sts_btn_level(sts_btn_level), .sts_btn_irq(sts_btn_irq), .btn_irq(btn_irq),
    .sts_emerg_off(sts_emerg_off), .sts_sw_off(sts_sw_off),
    .pmic_on_req(pmic_on_req)
  );

  // ---------------- behavioural reference model ----------------
  int m_s1, m_s2, m_db, m_dbp, m_cnt, m_lp, m_on, m_armed, m_pwr;
  int m_irq, m_eo, m_spo;

  function automatic int db_lim(input int s);
    return (s == 0) ? 50 : (s == 1) ? 100 : (s == 2) ? 500 : 0;
  endfunction
  function automatic int lp_lim(input int s);
    return (s == 0) ? 5000 : (s == 1) ? 10000 : (s == 2) ? 15000 : 0;
  endfunction
  function automatic int on_lim(input int s);
    return (s == 0) ? 500 : (s == 1) ? 50 : (s == 2) ? 100 : 0;
  endfunction
  function automatic int pressed_of(input int md, input int lvl);
    if (md == 0 || md == 3) return (lvl == 0) ? 1 : 0;
    if (md == 1 || md == 2 || md == 4) return lvl;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_db = 0; m_dbp = 0; m_cnt = 0; m_lp = 0; m_on = 0;
      m_armed = 0; m_pwr = 1; m_irq = 0; m_eo = 0; m_spo = 0;
    end else begin
      int p, ev, n_db, n_cnt, hit, onhit, n_lp, n_on, n_armed, n_pwr, lim, olim;
      p = pressed_of(cfg_mode, m_db);
      case (cfg_mode)
        3'd0: ev = (m_db == 0) ? 1 : 0;
        3'd1: ev = m_db;
        3'd2: ev = (m_db == 1 && m_dbp == 0) ? 1 : 0;
        3'd3: ev = (m_db == 0 && m_dbp == 1) ? 1 : 0;
        3'd4: ev = (m_db != m_dbp) ? 1 : 0;
        default: ev = 0;
      endcase
      n_db = m_db; n_cnt = m_cnt;
      if (m_s2 == m_db) n_cnt = 0;
      else if (cfg_debounce == 3) begin n_db = m_s2; n_cnt = 0; end
      else if (ms_tick) begin
        if (m_cnt + 1 >= db_lim(cfg_debounce)) begin n_db = m_s2; n_cnt = 0; end
        else n_cnt = m_cnt + 1;
      end
      lim = lp_lim(cfg_long_press);
      hit = (p && ms_tick && cfg_long_press != 3 && m_lp == lim - 1) ? 1 : 0;
      n_lp = !p ? 0 : ((ms_tick && m_lp < lim) ? m_lp + 1 : m_lp);
      olim = on_lim(cfg_on_time);
      onhit = (!m_pwr && m_armed && p &&
               (cfg_on_time == 3 || (ms_tick && m_on == olim - 1))) ? 1 : 0;
      n_on = (m_pwr || !m_armed || !p) ? 0 :
             ((ms_tick && m_on < olim) ? m_on + 1 : m_on);
      n_armed = m_pwr ? 0 : (!p ? 1 : m_armed);
      n_pwr = (hit || cmd_power_off) ? 0 : (onhit ? 1 : m_pwr);
      m_irq = ev ? 1 : (clr_btn_irq ? 0 : m_irq);
      m_eo  = hit ? 1 : (clr_emerg ? 0 : m_eo);
      m_spo = cmd_power_off ? 1 : (clr_sw_off ? 0 : m_spo);
      m_dbp = m_db; m_db = n_db; m_cnt = n_cnt;
      m_s2 = m_s1; m_s1 = btn_raw;
      m_lp = n_lp; m_on = n_on; m_armed = n_armed; m_pwr = n_pwr;
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Compare every output with the model on every cycle, mid-period.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R3 level", int'(sts_btn_level), pressed_of(cfg_mode, m_db));
      cmp("R4 flag", int'(sts_btn_irq), m_irq);
      cmp("R6 masked irq", int'(btn_irq), (m_irq != 0 && !cfg_irq_mask) ? 1 : 0);
      cmp("R7 emergency off", int'(sts_emerg_off), m_eo);
      cmp("R9 software off", int'(sts_sw_off), m_spo);
      cmp("R10 on request", int'(pmic_on_req),
          (cfg_req_force || (cfg_req_enable && m_pwr != 0)) ? 1 : 0);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      phase++;
      ms_tick = ((phase % tick_div) == 0);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    cmp(req, act, exp);
  endtask

  task automatic clr_irq_pulse();
    clr_btn_irq = 1'b1; cyc(1); clr_btn_irq = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R11: reset state
    chk("R11 level", int'(sts_btn_level), 0);
    chk("R11 flag", int'(sts_btn_irq), 0);
    chk("R11 eo", int'(sts_emerg_off), 0);
    chk("R11 spo", int'(sts_sw_off), 0);
    chk("R10 powered after reset", int'(pmic_on_req), 1);

    // R1: 50-tick debounce, active high
    btn_raw = 1; cyc(40);
    chk("R1 not yet debounced", int'(sts_btn_level), 0);
    cyc(20);
    chk("R1 debounced", int'(sts_btn_level), 1);
    chk("R4 level mode sets", int'(sts_btn_irq), 1);

    // R5: clear while held loses to the level set
    clr_irq_pulse();
    chk("R5 set wins", int'(sts_btn_irq), 1);
    btn_raw = 0; cyc(60);
    clr_irq_pulse();
    chk("R5 cleared", int'(sts_btn_irq), 0);

    // R6: mask gates the output only
    cfg_irq_mask = 1; btn_raw = 1; cyc(60);
    chk("R6 flag still sets", int'(sts_btn_irq), 1);
    chk("R6 output masked", int'(btn_irq), 0);
    cfg_irq_mask = 0; cyc(1);
    chk("R6 unmasked", int'(btn_irq), 1);
    btn_raw = 0; cyc(60); clr_irq_pulse();

    // R2: no debounce, three-edge latency
    cfg_debounce = 3; btn_raw = 1; cyc(2);
    chk("R2 before third edge", int'(sts_btn_level), 0);
    cyc(1);
    chk("R2 at third edge", int'(sts_btn_level), 1);
    btn_raw = 0; cyc(5); clr_irq_pulse();

    // R4: edge modes
    cfg_mode = 3'd2; cyc(2); clr_irq_pulse();
    chk("R4 rise mode idle", int'(sts_btn_irq), 0);
    btn_raw = 1; cyc(5);
    chk("R4 rise seen", int'(sts_btn_irq), 1);
    clr_irq_pulse(); btn_raw = 0; cyc(5);
    chk("R4 fall ignored in rise mode", int'(sts_btn_irq), 0);
    cfg_mode = 3'd3; btn_raw = 1; cyc(5);
    chk("R4 rise ignored in fall mode", int'(sts_btn_irq), 0);
    btn_raw = 0; cyc(5);
    chk("R4 fall seen", int'(sts_btn_irq), 1);
    chk("R3 fall mode low is pressed", int'(sts_btn_level), 1);
    clr_irq_pulse();
    cfg_mode = 3'd4; btn_raw = 1; cyc(5);
    chk("R4 any edge rise", int'(sts_btn_irq), 1);
    clr_irq_pulse(); btn_raw = 0; cyc(5);
    chk("R4 any edge fall", int'(sts_btn_irq), 1);
    clr_irq_pulse();
    cfg_mode = 3'd6; cyc(2);
    chk("R3 reserved mode never pressed", int'(sts_btn_level), 0);
    cfg_mode = 3'd0; cyc(2);
    chk("R3 active low pressed", int'(sts_btn_level), 1);
    cfg_mode = 3'd1; cyc(2); clr_irq_pulse();

    // R1: glitch shorter than 100 ticks with sparse ticks
    tick_div = 3; cfg_debounce = 1;
    btn_raw = 1; cyc(200); btn_raw = 0; cyc(50);
    chk("R1 glitch filtered", int'(sts_btn_level), 0);
    btn_raw = 1; cyc(400);
    chk("R1 slow ticks accept", int'(sts_btn_level), 1);
    btn_raw = 0; cyc(400);
    chk("R1 slow ticks release", int'(sts_btn_level), 0);
    tick_div = 1; cfg_debounce = 3; clr_irq_pulse();

    // R7: 5000-tick long press
    cfg_long_press = 0; btn_raw = 1; cyc(4990);
    chk("R7 before limit", int'(sts_emerg_off), 0);
    cyc(20);
    chk("R7 emergency off", int'(sts_emerg_off), 1);
    chk("R7 power dropped", int'(pmic_on_req), 0);
    btn_raw = 0; cyc(5);
    clr_emerg = 1; cyc(1); clr_emerg = 0;
    chk("R12 eo cleared", int'(sts_emerg_off), 0);

    // R8: 50-tick on-time, short press then long enough press
    cfg_on_time = 1; btn_raw = 1; cyc(30); btn_raw = 0; cyc(5);
    chk("R8 short press stays off", int'(pmic_on_req), 0);
    btn_raw = 1; cyc(45);
    chk("R8 before on-time", int'(pmic_on_req), 0);
    cyc(15);
    chk("R8 powered on", int'(pmic_on_req), 1);
    btn_raw = 0; cyc(5);

    // R9 / R12: software power off, clear collision
    cmd_power_off = 1; cyc(1); cmd_power_off = 0;
    chk("R9 spo set", int'(sts_sw_off), 1);
    chk("R9 power off", int'(pmic_on_req), 0);
    cmd_power_off = 1; clr_sw_off = 1; cyc(1);
    cmd_power_off = 0; clr_sw_off = 0;
    chk("R12 set wins", int'(sts_sw_off), 1);
    clr_sw_off = 1; cyc(1); clr_sw_off = 0;
    chk("R12 spo cleared", int'(sts_sw_off), 0);

    // R8: immediate on-time
    cfg_on_time = 3; cyc(2); btn_raw = 1; cyc(2);
    chk("R8 immediate not yet", int'(pmic_on_req), 0);
    cyc(4);
    chk("R8 immediate on", int'(pmic_on_req), 1);
    btn_raw = 0; cyc(5); clr_irq_pulse();

    // R7: disabled long press
    cfg_long_press = 3; btn_raw = 1; cyc(16000);
    chk("R7 disabled no eo", int'(sts_emerg_off), 0);
    chk("R7 disabled stays on", int'(pmic_on_req), 1);
    btn_raw = 0; cyc(5);

    // R7: 15000-tick long press
    cfg_long_press = 2; btn_raw = 1; cyc(14990);
    chk("R7 15000 before", int'(sts_emerg_off), 0);
    cyc(20);
    chk("R7 15000 fires", int'(sts_emerg_off), 1);
    btn_raw = 0; cyc(5);
    clr_emerg = 1; cyc(1); clr_emerg = 0;

    // R7: 10000-tick long press (re-powers immediately, then fires)
    cfg_long_press = 1; btn_raw = 1; cyc(9990);
    chk("R7 10000 before", int'(sts_emerg_off), 0);
    cyc(20);
    chk("R7 10000 fires", int'(sts_emerg_off), 1);
    btn_raw = 0; cyc(5);

    // R10: force and enable
    cfg_long_press = 3; cmd_power_off = 1; cyc(1); cmd_power_off = 0;
    cfg_req_force = 1; cyc(1);
    chk("R10 forced while off", int'(pmic_on_req), 1);
    cfg_req_force = 0; cyc(1);
    chk("R10 off without force", int'(pmic_on_req), 0);
    btn_raw = 1; cyc(6); btn_raw = 0; cyc(3);
    chk("R10 on again", int'(pmic_on_req), 1);
    cfg_req_enable = 0; cyc(1);
    chk("R10 enable gates", int'(pmic_on_req), 0);
    cfg_req_enable = 1; cyc(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule